// File: doc/BRIEF.md
# S/PDIF Receiver Control and Status Unit

This block is the register-side core of an S/PDIF receiver. It holds the mode field that moves the receiver from off, through lock hunting, to full reception. It also holds the interrupt enables and a set of sticky event and error flags. Single-cycle pulses from the line decoder raise these flags. The flags are cleared in three ways: by write-one-to-clear, by reading a data port, or by switching the receiver off.

Software drives a narrow word-addressed read/write port. The decoder sees the current mode, a hunt strobe that permits lock attempts, and the data-request enable. One level-sensitive interrupt line combines every flag with its enable.

Top module: `spdif_rx_ctrl`

## Requirements
- R1: The mode field (control bits 1:0) encodes off as 00, hunt-only as 01 and full reception as 11, and appears on `rx_mode`. A control write whose mode field is 10 leaves the mode unchanged but still updates the other control fields.
- R2: Word addresses are 0 control, 1 interrupt enable, 2 status, 3 clear, 4 data port, 5 channel-status port; all others read zero. Control bit 2 is the data-request enable, bit 3 the wait-for-activity switch, bits 5:4 the retry code. After reset every register reads zero.
- R3: Status bits are: 0 data ready, 1 channel-status ready, 2 parity error, 3 overrun, 4 block start, 5 lock done, 6 frame error, 7 lock error, 8 timeout. With the mode off, every event pulse is ignored. Bits 0 to 4 are raised only in full reception; frame error and timeout are raised in any mode other than off.
- R4: A data event sets data ready; a read of address 4 clears it, unless a data event arrives in the same cycle.
- R5: A data event while data ready is set, and that ready is not being read in the same cycle, sets overrun.
- R6: A channel-status event sets bit 1; a read of address 5 clears it.
- R7: Writing 1 to clear-register bits 2 to 5 clears parity error, overrun, block start and lock done. Other clear bits do nothing. An event in the same cycle keeps its flag set.
- R8: Frame error, lock error and timeout are cleared only by writing mode 00. That write also forces the data-request enable to 0 and resets the hunt state.
- R9: `hunt` is high while the mode is not off, lock has not been reached or abandoned, and either wait-for-activity is clear or an activity pulse has arrived since the receiver was switched on.
- R10: Retry codes 0,1,2,3 tolerate 0, 3, 15 or 63 failed lock attempts. The next failure sets lock error and drops `hunt`.
- R11: A lock success pulse while hunting sets lock done and drops `hunt`; a success and a failure in the same cycle count as a success.
- R12: `irq` is the OR of status bits 0..6 each ANDed with the same-numbered enable bit, plus enable bit 6 ANDed with status bits 7 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (read side effects) |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_data | input | 1 | Decoder: audio word captured |
| ev_chan_stat | input | 1 | Decoder: channel-status word captured |
| ev_parity | input | 1 | Decoder: parity error |
| ev_block_start | input | 1 | Decoder: block start seen |
| ev_activity | input | 1 | Decoder: line transitions seen |
| ev_lock_ok | input | 1 | Decoder: lock attempt succeeded |
| ev_lock_fail | input | 1 | Decoder: lock attempt failed |
| ev_frame_err | input | 1 | Decoder: frame error |
| ev_timeout | input | 1 | Decoder: timeout |
| rx_mode | output | 2 | Current mode field |
| dma_en | output | 1 | Data-request enable |
| hunt | output | 1 | Lock attempts permitted |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong flag or control bit shows at the status read and on `irq` one clock after the offending pulse or write. A wrong retry count or activity latch shows as `hunt` staying high or dropping a clock too early or too late. The bench's behavioural model predicts every output on every cycle, so a discrepancy is reported in the first cycle it reaches a port.

// File: rtl/spdif_rx_pkg.sv
package spdif_rx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HUNT = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_RUN  = 2'b11
  } rx_mode_e;

  localparam int FLAG_N   = 9;
  localparam int MASK_N   = 7;
  localparam int RETRY_W  = 2;

  localparam int F_RDY    = 0;
  localparam int F_CSRDY  = 1;
  localparam int F_PAR    = 2;
  localparam int F_OVR    = 3;
  localparam int F_BLK    = 4;
  localparam int F_LOCK   = 5;
  localparam int F_FRAME  = 6;
  localparam int F_LERR   = 7;
  localparam int F_TOUT   = 8;

  localparam int A_CTRL   = 0;
  localparam int A_MASK   = 1;
  localparam int A_STAT   = 2;
  localparam int A_CLR    = 3;
  localparam int A_DATA   = 4;
  localparam int A_CSTAT  = 5;

  localparam int C_DMA    = 2;
  localparam int C_WAIT   = 3;
  localparam int C_RETRY  = 4;
endpackage

// File: rtl/spdif_rx_flags.sv
module spdif_rx_flags #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic         flag_we;

  always_comb begin
    flag_d  = (flag_q & ~clr_i) | set_i;
    flag_we = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_o[k]);
  end
endmodule

// File: rtl/spdif_rx_sync.sv
module spdif_rx_sync #(
  parameter int RETRY_W = 2,
  localparam int CNT_W  = 2 * ((1 << RETRY_W) - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_i,
  input  logic               restart_i,
  input  logic               wait_act_i,
  input  logic [RETRY_W-1:0] retry_i,
  input  logic               ev_activity_i,
  input  logic               ev_ok_i,
  input  logic               ev_fail_i,
  output logic               hunt_o,
  output logic               done_o,
  output logic               err_o
);
  logic             seen_q, seen_d;
  logic             locked_q, locked_d;
  logic             failed_q, failed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             fail_step;
  logic             st_we;

  for (genvar i = 0; i < CNT_W; i++) begin : g_lim
    assign limit[i] = (i < 2 * int'(retry_i));
  end

  always_comb begin
    hunt_o    = on_i && !locked_q && !failed_q && (!wait_act_i || seen_q);
    done_o    = hunt_o && ev_ok_i;
    fail_step = hunt_o && ev_fail_i && !ev_ok_i;
    err_o     = fail_step && (cnt_q >= limit);
    seen_d    = seen_q | (on_i && ev_activity_i);
    locked_d  = locked_q | done_o;
    failed_d  = failed_q | err_o;
    cnt_d     = (fail_step && !err_o) ? cnt_q + 1'b1 : cnt_q;
    if (restart_i) begin
      seen_d   = 1'b0;
      locked_d = 1'b0;
      failed_d = 1'b0;
      cnt_d    = '0;
    end
    st_we = restart_i || ev_activity_i || done_o || fail_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      failed_q <= 1'b0;
      cnt_q    <= '0;
    end else if (st_we) begin
      seen_q   <= seen_d;
      locked_q <= locked_d;
      failed_q <= failed_d;
      cnt_q    <= cnt_d;
    end
  end

  assert_stop_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !restart_i) |=> !hunt_o);
  assert_stop_on_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !restart_i) |=> !hunt_o);
  assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && wait_act_i) |=> !hunt_o);
endmodule

// File: rtl/spdif_rx_ctrl.sv
module spdif_rx_ctrl
  import spdif_rx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_data,
  input  logic              ev_chan_stat,
  input  logic              ev_parity,
  input  logic              ev_block_start,
  input  logic              ev_activity,
  input  logic              ev_lock_ok,
  input  logic              ev_lock_fail,
  input  logic              ev_frame_err,
  input  logic              ev_timeout,
  output logic [1:0]        rx_mode,
  output logic              dma_en,
  output logic              hunt,
  output logic              irq
);
  rx_mode_e           mode_q, mode_d;
  logic               dma_q, dma_d;
  logic               wait_q, wait_d;
  logic [RETRY_W-1:0] retry_q, retry_d;
  logic [MASK_N-1:0]  mask_q;
  logic [FLAG_N-1:0]  flags, set_v, clr_v;
  logic               ctrl_wr, mask_wr, clr_wr, off_wr;
  logic               rd_dat, rd_cs, on, run;
  logic               lock_done, lock_err;
  rx_mode_e           wr_mode;

  always_comb begin
    ctrl_wr = wr_en && (int'(wr_addr) == A_CTRL);
    mask_wr = wr_en && (int'(wr_addr) == A_MASK);
    clr_wr  = wr_en && (int'(wr_addr) == A_CLR);
    wr_mode = rx_mode_e'(wr_data[1:0]);
    off_wr  = ctrl_wr && (wr_mode == MODE_OFF);
    rd_dat  = rd_en && (int'(rd_addr) == A_DATA);
    rd_cs   = rd_en && (int'(rd_addr) == A_CSTAT);
    on      = (mode_q != MODE_OFF);
    run     = (mode_q == MODE_RUN);
  end

  always_comb begin
    mode_d  = mode_q;
    dma_d   = dma_q;
    wait_d  = wait_q;
    retry_d = retry_q;
    if (ctrl_wr) begin
      if (wr_mode != MODE_RSVD) mode_d = wr_mode;
      dma_d   = wr_data[C_DMA] && !off_wr;
      wait_d  = wr_data[C_WAIT];
      retry_d = wr_data[C_RETRY +: RETRY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      dma_q   <= 1'b0;
      wait_q  <= 1'b0;
      retry_q <= '0;
    end else if (ctrl_wr) begin
      mode_q  <= mode_d;
      dma_q   <= dma_d;
      wait_q  <= wait_d;
      retry_q <= retry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data[MASK_N-1:0];
  end

  spdif_rx_sync #(.RETRY_W(RETRY_W)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .on_i         (on),
    .restart_i    (off_wr),
    .wait_act_i   (wait_q),
    .retry_i      (retry_q),
    .ev_activity_i(ev_activity),
    .ev_ok_i      (ev_lock_ok),
    .ev_fail_i    (ev_lock_fail),
    .hunt_o       (hunt),
    .done_o       (lock_done),
    .err_o        (lock_err)
  );

  always_comb begin
    set_v          = '0;
    set_v[F_RDY]   = run && ev_data;
    set_v[F_CSRDY] = run && ev_chan_stat;
    set_v[F_PAR]   = run && ev_parity;
    set_v[F_OVR]   = run && ev_data && flags[F_RDY] && !rd_dat;
    set_v[F_BLK]   = run && ev_block_start;
    set_v[F_LOCK]  = lock_done;
    set_v[F_FRAME] = on && ev_frame_err && !off_wr;
    set_v[F_LERR]  = lock_err && !off_wr;
    set_v[F_TOUT]  = on && ev_timeout && !off_wr;

    clr_v          = '0;
    clr_v[F_RDY]   = rd_dat;
    clr_v[F_CSRDY] = rd_cs;
    for (int b = F_PAR; b <= F_LOCK; b++) clr_v[b] = clr_wr && wr_data[b];
    for (int b = F_FRAME; b <= F_TOUT; b++) clr_v[b] = off_wr;
  end

  spdif_rx_flags #(.N(FLAG_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flags_o(flags)
  );

  always_comb begin
    irq = (|(flags[MASK_N-1:0] & mask_q)) ||
          (mask_q[F_FRAME] && (flags[F_LERR] || flags[F_TOUT]));
  end

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      A_CTRL: begin
        rd_data[1:0]                = mode_q;
        rd_data[C_DMA]              = dma_q;
        rd_data[C_WAIT]             = wait_q;
        rd_data[C_RETRY +: RETRY_W] = retry_q;
      end
      A_MASK:  rd_data[MASK_N-1:0] = mask_q;
      A_STAT:  rd_data[FLAG_N-1:0] = flags;
      default: rd_data = '0;
    endcase
  end

  assign rx_mode = mode_q;
  assign dma_en  = dma_q;

  assert_rsvd_keeps_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[1:0] == 2'b10) |=> (rx_mode == $past(rx_mode)));
  assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_wr |=> (!dma_en && flags[F_TOUT:F_FRAME] == '0));
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !ev_data) |=> !flags[F_RDY]);
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  assert_off_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !rd_en && !wr_en) |=> $stable(flags));
endmodule

// File: tb/spdif_rx_ctrl_tb.sv
module spdif_rx_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic ev_data = 0, ev_chan_stat = 0, ev_parity = 0, ev_block_start = 0;
  logic ev_activity = 0, ev_lock_ok = 0, ev_lock_fail = 0, ev_frame_err = 0, ev_timeout = 0;
  logic [1:0]  rx_mode;
  logic        dma_en, hunt, irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_rx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_data(ev_data), .ev_chan_stat(ev_chan_stat), .ev_parity(ev_parity),
    .ev_block_start(ev_block_start), .ev_activity(ev_activity),
    .ev_lock_ok(ev_lock_ok), .ev_lock_fail(ev_lock_fail),
    .ev_frame_err(ev_frame_err), .ev_timeout(ev_timeout),
    .rx_mode(rx_mode), .dma_en(dma_en), .hunt(hunt), .irq(irq)
  );

  // behavioural reference state
  logic [1:0] m_en, m_retry;
  logic       m_dma, m_wait, m_seen, m_locked, m_failed;
  int         m_cnt;
  logic [6:0] m_mask;
  logic [8:0] m_fl;

  function automatic logic m_hunt();
    return (m_en != 0) && !m_locked && !m_failed && (!m_wait || m_seen);
  endfunction

  function automatic logic m_irq();
    return (|(m_fl[6:0] & m_mask)) || (m_mask[6] && (m_fl[7] || m_fl[8]));
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {26'd0, m_retry, m_wait, m_dma, m_en};
      3'd1: return {25'd0, m_mask};
      3'd2: return {23'd0, m_fl};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic on, run, h, rdd;
    logic [8:0] f;
    int lim;
    if (!rst_n) begin
      m_en = 0; m_retry = 0; m_dma = 0; m_wait = 0; m_seen = 0;
      m_locked = 0; m_failed = 0; m_cnt = 0; m_mask = 0; m_fl = 0;
    end else begin
      on  = (m_en != 0);
      run = (m_en == 3);
      h   = m_hunt();
      lim = (1 << (2 * m_retry)) - 1;
      rdd = rd_en && rd_addr == 3'd4;
      f   = m_fl;
      if (wr_en && wr_addr == 3'd3) f[5:2] = f[5:2] & ~wr_data[5:2];
      if (rdd) f[0] = 0;
      if (rd_en && rd_addr == 3'd5) f[1] = 0;
      if (run && ev_data) begin
        if (m_fl[0] && !rdd) f[3] = 1;
        f[0] = 1;
      end
      if (run && ev_chan_stat) f[1] = 1;
      if (run && ev_parity) f[2] = 1;
      if (run && ev_block_start) f[4] = 1;
      if (on && ev_frame_err) f[6] = 1;
      if (on && ev_timeout) f[8] = 1;
      if (h && ev_lock_ok) begin
        m_locked = 1; f[5] = 1;
      end else if (h && ev_lock_fail) begin
        if (m_cnt >= lim) begin m_failed = 1; f[7] = 1; end
        else m_cnt++;
      end
      if (on && ev_activity) m_seen = 1;
      if (wr_en && wr_addr == 3'd1) m_mask = wr_data[6:0];
      if (wr_en && wr_addr == 3'd0) begin
        if (wr_data[1:0] != 2'b10) m_en = wr_data[1:0];
        m_dma = wr_data[2]; m_wait = wr_data[3]; m_retry = wr_data[5:4];
        if (wr_data[1:0] == 2'b00) begin
          m_dma = 0; f[8:6] = 0;
          m_seen = 0; m_locked = 0; m_failed = 0; m_cnt = 0;
        end
      end
      m_fl = f;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 rx_mode", 32'(rx_mode), 32'(m_en));
      check("R8 dma_en", 32'(dma_en), 32'(m_dma));
      check("R9 hunt", 32'(hunt), 32'(m_hunt()));
      check("R12 irq", 32'(irq), 32'(m_irq()));
      check("R3 rd_data", rd_data, m_read(rd_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    rd_en = 1; rd_addr = a;
    #1 check(tag, rd_data, exp);
    @(negedge clk); #1;
    rd_en = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk); #1;
    case (which)
      0: ev_data = 1;        1: ev_chan_stat = 1;  2: ev_parity = 1;
      3: ev_block_start = 1; 4: ev_activity = 1;   5: ev_lock_ok = 1;
      6: ev_lock_fail = 1;   7: ev_frame_err = 1;  default: ev_timeout = 1;
    endcase
    @(negedge clk); #1;
    {ev_data, ev_chan_stat, ev_parity, ev_block_start, ev_activity,
     ev_lock_ok, ev_lock_fail, ev_frame_err, ev_timeout} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd(3'd2, 32'h0, "R2 status after reset");
    rd(3'd0, 32'h0, "R2 control after reset");
    for (int e = 0; e < 9; e++) pulse(e);
    rd(3'd2, 32'h0, "R3 events ignored while off");
    // hunt-only, wait for activity, retry code 1 (3 tolerated)
    wr(3'd0, 32'h19);
    @(negedge clk); check("R9 hunt held before activity", 32'(hunt), 32'h0);
    pulse(4);
    @(negedge clk); check("R9 hunt after activity", 32'(hunt), 32'h1);
    for (int i = 0; i < 3; i++) pulse(6);
    rd(3'd2, 32'h0, "R10 three failures tolerated");
    pulse(6);
    rd(3'd2, 32'h80, "R10 fourth failure sets lock error");
    check("R10 hunt dropped", 32'(hunt), 32'h0);
    rd(3'd0, 32'h19, "R2 control fields");
    wr(3'd3, 32'h1FF);
    rd(3'd2, 32'h80, "R8 lock error survives clear write");
    wr(3'd0, 32'h0);
    rd(3'd2, 32'h0, "R8 off clears lock error");
    // lock success with interrupt
    wr(3'd1, 32'h20);
    wr(3'd0, 32'h01);
    pulse(5);
    rd(3'd2, 32'h20, "R11 lock done");
    check("R11 hunt dropped", 32'(hunt), 32'h0);
    check("R12 irq on lock done", 32'(irq), 32'h1);
    wr(3'd3, 32'h20);
    rd(3'd2, 32'h0, "R7 clear lock done");
    // full reception with data request
    wr(3'd0, 32'h07);
    pulse(0);
    rd(3'd2, 32'h01, "R4 data ready");
    pulse(0);
    rd(3'd2, 32'h09, "R5 overrun");
    rd(3'd4, 32'h0, "R4 data port read");
    rd(3'd2, 32'h08, "R4 read cleared ready");
    pulse(1);
    rd(3'd2, 32'h0A, "R6 channel status ready");
    rd(3'd5, 32'h0, "R6 port read");
    rd(3'd2, 32'h08, "R6 read cleared");
    pulse(2); pulse(3);
    rd(3'd2, 32'h1C, "R3 parity and block start");
    wr(3'd3, 32'h1FF);
    rd(3'd2, 32'h0, "R7 clear bits 2..5");
    pulse(7);
    wr(3'd3, 32'h1FF);
    rd(3'd2, 32'h40, "R8 frame error survives clear write");
    wr(3'd0, 32'h0E);
    rd(3'd0, 32'h0F, "R1 reserved mode ignored");
    wr(3'd0, 32'h04);
    rd(3'd0, 32'h0, "R8 off forces data request off");
    rd(3'd2, 32'h0, "R8 off clears frame error");
    // timeout through enable bit 6
    wr(3'd1, 32'h40);
    wr(3'd0, 32'h01);
    pulse(8);
    rd(3'd2, 32'h100, "R3 timeout");
    check("R12 irq via bit 6 for timeout", 32'(irq), 32'h1);
    wr(3'd1, 32'h0);
    @(negedge clk); check("R12 irq masked", 32'(irq), 32'h0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule